// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Register

This block gathers eight interrupt sources into one 8-bit register of sticky pending flags. A small controller's CPU reads these flags and clears them. Three sources are overflow pulses from timers and counters. These pulses are synchronous to the clock and last one cycle. The other five are asynchronous levels: four external pins and the output of a tone detector. Each level passes through a two-stage synchronizer. An edge detector then applies the trigger rule for that source.

A second 8-bit register holds the enable mask. A flag drives the single request line to the CPU only when its mask bit is 1. The mask has no effect on flag capture. Software reaches both registers through a simple port: a write strobe, a register select and write data. Reads use a combinational read mux with its own select.

Flag bit assignment: bits 0, 1 and 2 are the overflow pulses 0, 1 and 2. Bit 3 is pin 0. Bits 4 and 5 are pins 1 and 2. Bit 6 is the tone detector. Bit 7 is pin 3.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset the flag register and the mask register both read 0x00, and `irq_o` is 0.
- R2: A 1 on `ovf_pulse_i[k]` (k = 0, 1, 2) in a cycle sets flag bit k at that clock edge. The flag is visible in the next cycle.
- R3: Pin 0 (`ext_pin_i[0]`) sets flag bit 3. When `pin0_rise_sel_i` = 1 only a rising edge sets it. When it is 0 only a falling edge sets it.
- R4: Pins 1, 2 and 3 set flag bits 4, 5 and 7 on a falling edge only. A rising edge on these pins leaves the flags at 0.
- R5: The tone input `tone_det_i` sets flag bit 6. When `tone_both_edge_i` = 0 only a falling edge sets it. When it is 1 either edge sets it.
- R6: Each level input is synchronized by two flops, and edges are found by comparing the result with its previous value. A change applied before clock edge n sets the flag at edge n+2. It does not set it at edge n+1.
- R7: A write with `wr_sel_i` = 0 clears each flag whose written bit is 0. A flag whose written bit is 1 is left unchanged, so a write can never set a flag.
- R8: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: A write with `wr_sel_i` = 1 loads the mask. With `rd_sel_i` = 1, `rd_data_o` returns the mask. With `rd_sel_i` = 0, it returns the flags.
- R10: `irq_o` is 1 exactly when some flag and its mask bit are both 1. Flags are captured whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovf_pulse_i | input | 3 | One-cycle overflow pulses for flag bits 0..2 |
| ext_pin_i | input | 4 | Asynchronous external pins 0..3 |
| tone_det_i | input | 1 | Asynchronous tone-detector output |
| pin0_rise_sel_i | input | 1 | Pin 0 trigger: 1 rising, 0 falling |
| tone_both_edge_i | input | 1 | Tone trigger: 1 both edges, 0 falling only |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 flags, 1 mask |
| wr_data_i | input | 8 | Write data (for flags: 0 clears, 1 keeps) |
| rd_sel_i | input | 1 | Read select: 0 flags, 1 mask |
| rd_data_o | output | 8 | Read data |
| flags_o | output | 8 | Pending flag register |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The assertions assume four things about the inputs. Overflow pulses are already synchronous to the clock. Reset leaves all level inputs at their idle high level, so no edge comes out of reset. A change in the trigger mode, with the input level held steady, must not create an edge by itself. The stimulus meets these rules in three ways. It drives all inputs on the falling clock edge and holds each pin at its starting level for several cycles before a flag clear. It changes a trigger mode only while the input is steady. It then applies a single edge and samples one cycle before and exactly at the expected capture edge.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int NUM_FLAGS    = 8;
  localparam int NUM_OVF      = 3;
  localparam int NUM_PINS     = 4;
  localparam int NUM_EDGE_SRC = NUM_PINS + 1;
  localparam int TONE_SRC     = NUM_PINS;

  typedef enum logic {
    SEL_FLAGS = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;

  // Flag position of each level source: pins 0..3, then tone.
  function automatic int edge_bit(input int src);
    case (src)
      0:       edge_bit = 3;
      1:       edge_bit = 4;
      2:       edge_bit = 5;
      3:       edge_bit = 7;
      default: edge_bit = 6;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= {WIDTH{RST_VAL}};
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {WIDTH{RST_VAL}};
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int   WIDTH   = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] rise_en_i,
  input  logic [WIDTH-1:0] fall_en_i,
  output logic [WIDTH-1:0] pulse_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= {WIDTH{RST_VAL}};
    else         prev_q <= lvl_i;
  end

  always_comb begin
    rise    = lvl_i & ~prev_q;
    fall    = ~lvl_i & prev_q;
    pulse_o = (rise & rise_en_i) | (fall & fall_en_i);
  end

  // R6
  edge_needs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o & ~(lvl_i ^ $past(lvl_i))) == '0);

  // R4
  no_rise_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o & lvl_i & ~rise_en_i) == '0);

  // R5
  no_fall_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o & ~lvl_i & ~fall_en_i) == '0);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] keep_i,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (clr_en_i) flags_d = flags_d & keep_i;
    flags_d = flags_d | set_i;  // set wins over clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R8
  set_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  // R7
  clear_applied_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((flags_q & ~$past(keep_i) & ~$past(set_i)) == '0));

  // R7
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q & ~$past(flags_q) & ~$past(set_i)) == '0);
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] flags_i,
  output logic [WIDTH-1:0] mask_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_en_i) mask_q <= wr_data_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(flags_i & mask_q);

  // R9
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mask_q == $past(wr_data_i)));

  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_OVF-1:0]   ovf_pulse_i,
  input  logic [NUM_PINS-1:0]  ext_pin_i,
  input  logic                 tone_det_i,
  input  logic                 pin0_rise_sel_i,
  input  logic                 tone_both_edge_i,
  input  logic                 wr_en_i,
  input  logic                 wr_sel_i,
  input  logic [NUM_FLAGS-1:0] wr_data_i,
  input  logic                 rd_sel_i,
  output logic [NUM_FLAGS-1:0] rd_data_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_o
);
  logic [NUM_EDGE_SRC-1:0] raw_lvl, sync_lvl, rise_en, fall_en, edge_pulse;
  logic [NUM_FLAGS-1:0]    set_vec, mask;
  logic                    flag_wr, mask_wr;

  assign raw_lvl = {tone_det_i, ext_pin_i};

  always_comb begin
    rise_en = '0;
    fall_en = '1;
    rise_en[0]        = pin0_rise_sel_i;
    fall_en[0]        = ~pin0_rise_sel_i;
    rise_en[TONE_SRC] = tone_both_edge_i;
  end

  irq_sync #(.WIDTH(NUM_EDGE_SRC), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_lvl),
    .q_o    (sync_lvl)
  );

  irq_edge_det #(.WIDTH(NUM_EDGE_SRC), .RST_VAL(1'b1)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (sync_lvl),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .pulse_o   (edge_pulse)
  );

  always_comb begin
    set_vec = '0;
    set_vec[NUM_OVF-1:0] = ovf_pulse_i;
    for (int e = 0; e < NUM_EDGE_SRC; e++) set_vec[edge_bit(e)] = edge_pulse[e];
  end

  assign flag_wr = wr_en_i && (wr_sel_i == SEL_FLAGS);
  assign mask_wr = wr_en_i && (wr_sel_i == SEL_MASK);

  irq_flag_bank #(.WIDTH(NUM_FLAGS)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_en_i (flag_wr),
    .keep_i   (wr_data_i),
    .flags_o  (flags_o)
  );

  irq_mask_gate #(.WIDTH(NUM_FLAGS)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (mask_wr),
    .wr_data_i (wr_data_i),
    .flags_i   (flags_o),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  assign rd_data_o = (rd_sel_i == SEL_MASK) ? mask : flags_o;

  // R2
  ovf_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_pulse_i != '0) |=> (($past(ovf_pulse_i) & ~flags_o[NUM_OVF-1:0]) == '0));

  // R10
  no_irq_without_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o == '0) |-> !irq_o);

  // R10
  irq_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);

  // R1
  reset_clean_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (flags_o == '0 && !irq_o));
endmodule

// File: tb/tb_irq_flag_reg.sv
`timescale 1ns/1ps
module tb_irq_flag_reg;
  localparam real HALF = 2.5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] ovf_pulse_i = '0;
  logic [3:0] ext_pin_i = '1;
  logic       tone_det_i = 1'b1;
  logic       pin0_rise_sel_i = 1'b0;
  logic       tone_both_edge_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_sel_i = 1'b0;
  logic [7:0] rd_data_o, flags_o;
  logic       irq_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #(HALF) clk = ~clk;

  irq_flag_reg dut (
    .clk_i(clk), .rst_ni(rst_ni), .ovf_pulse_i(ovf_pulse_i), .ext_pin_i(ext_pin_i),
    .tone_det_i(tone_det_i), .pin0_rise_sel_i(pin0_rise_sel_i),
    .tone_both_edge_i(tone_both_edge_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", req, got, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    tick(1);
    wr_en_i = 1'b0;
  endtask

  task automatic set_level(input int src, input logic v);
    if (src < 4) ext_pin_i[src] = v;
    else         tone_det_i = v;
  endtask

  // src 0..3 pins, 4 tone; mode is the rise select or both-edge control
  task automatic edge_case(input int src, input bit rising, input bit mode, input string req);
    int  bitpos;
    bit  hit;
    case (src)
      0: bitpos = 3; 1: bitpos = 4; 2: bitpos = 5; 3: bitpos = 7; default: bitpos = 6;
    endcase
    if (src == 0)      hit = mode ? rising : !rising;
    else if (src == 4) hit = !rising || mode;
    else               hit = !rising;
    pin0_rise_sel_i  = (src == 0) ? mode : 1'b0;
    tone_both_edge_i = (src == 4) ? mode : 1'b0;
    set_level(src, rising ? 1'b0 : 1'b1);
    tick(5);
    write_reg(1'b0, 8'h00);
    chk({req, " pre-edge clear"}, flags_o, 8'h00);
    set_level(src, rising ? 1'b1 : 1'b0);
    tick(2);
    chk("R6 not captured before third edge", flags_o, 8'h00);
    tick(1);
    chk(req, flags_o, hit ? (8'h01 << bitpos) : 8'h00);
    set_level(src, 1'b1);
    tick(5);
    write_reg(1'b0, 8'h00);
  endtask

  initial begin
    tick(3);
    chk("R1 flags after reset", flags_o, 8'h00);
    rd_sel_i = 1'b1;
    #0.1 chk("R1 mask after reset", rd_data_o, 8'h00);
    chk("R1 irq after reset", {7'b0, irq_o}, 8'h00);
    rd_sel_i = 1'b0;
    rst_ni = 1'b1;
    tick(3);

    for (int k = 0; k < 3; k++) begin
      ovf_pulse_i = 3'b001 << k;
      tick(1);
      ovf_pulse_i = '0;
      chk("R2 overflow capture", flags_o, 8'h01 << k);
      write_reg(1'b0, 8'h00);
    end

    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 2; r++) edge_case(0, r[0], m[0], "R3 pin0 edge");
    for (int p = 1; p < 4; p++)
      for (int r = 0; r < 2; r++) edge_case(p, r[0], 1'b0, "R4 falling-only pin");
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 2; r++) edge_case(4, r[0], m[0], "R5 tone edge");

    ovf_pulse_i = 3'b111; tick(1); ovf_pulse_i = '0;
    write_reg(1'b0, 8'hFD);
    chk("R7 zero bit clears", flags_o, 8'h05);
    write_reg(1'b0, 8'hFF);
    chk("R7 one bits cannot set", flags_o, 8'h05);

    write_reg(1'b0, 8'h00);
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 8'h00; ovf_pulse_i = 3'b001;
    tick(1);
    wr_en_i = 1'b0; ovf_pulse_i = '0;
    chk("R8 set beats clear", flags_o, 8'h01);

    for (int f = 0; f < 8; f++) begin
      write_reg(1'b0, 8'h00);
      write_reg(1'b1, 8'h00);
      ovf_pulse_i = f[2:0]; tick(1); ovf_pulse_i = '0;
      chk("R10 flags captured with mask clear", flags_o, 8'(f));
      for (int m = 0; m < 256; m++) begin
        write_reg(1'b1, 8'(m));
        rd_sel_i = 1'b1;
        #0.1 chk("R9 mask readback", rd_data_o, 8'(m));
        chk("R10 irq", {7'b0, irq_o}, {7'b0, |(8'(f) & 8'(m))});
        rd_sel_i = 1'b0;
        #0.1 chk("R9 flag readback", rd_data_o, 8'(f));
        tick(1);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog got 00 exp 01");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule